// File: doc/BRIEF.md
# Single-Price Coin Vending Controller

This block is the sequencing core of a drink dispenser that sells one item at a fixed price of 25 cents. Three coin inputs, one each for quarters, dimes and nickels, each carry a one-cycle pulse when a coin is accepted. The block keeps a running credit in 5-cent units. When the credit reaches the price, it raises a one-cycle vend strobe. It then pays back the excess as a train of one-cycle pulses on three return lines, one pulse per coin, with the largest coin first.

Coins that arrive while a vend or a payout is under way are not lost. They build a fresh credit for the next sale. If that fresh credit already covers the price when the payout ends, the next vend follows at once. Reset is synchronous and active high. All outputs come straight from flops, so they can drive the dispenser and the coin hoppers without glitches at the intended 100 MHz clock.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, all four outputs are low. Reset clears all credit, so a lone quarter after reset vends with no change.
- R2: Credit counts in 5-cent units: a quarter adds 5, a dime 2 and a nickel 1. While the credit is below 25 cents, no output pulses. For example, four nickels give nothing and the fifth nickel vends.
- R3: `vend` is high for exactly one cycle. That cycle is the one right after the clock edge that samples the coin bringing the credit to 25 cents or more.
- R4: Change begins in the cycle after `vend` and continues one pulse per cycle with no gaps. The total value returned equals the credit minus 25 cents.
- R5: Change is paid largest coin first (quarter, then dime, then nickel). 20 cents is paid as dime, dime. 15 cents is paid as dime, nickel. 10 cents is paid as one dime. 5 cents is paid as one nickel.
- R6: In any cycle, at most one of `vend`, `ret_q`, `ret_d` and `ret_n` is high.
- R7: Coins sampled during a vend or payout cycle go into a fresh credit.
  - If the fresh credit is at least 25 cents when the payout ends, a new `vend` fires in the cycle after the last pulse of that payout.
  - Otherwise the fresh credit is kept for the next purchase.
- R8: Over any coin sequence that ends with a completed purchase and a drained payout, value inserted minus value returned equals 25 cents times the number of `vend` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_q | input | 1 | One-cycle pulse: quarter accepted |
| coin_d | input | 1 | One-cycle pulse: dime accepted |
| coin_n | input | 1 | One-cycle pulse: nickel accepted |
| vend | output | 1 | One-cycle strobe: dispense one drink |
| ret_q | output | 1 | One-cycle pulse: return one quarter |
| ret_d | output | 1 | One-cycle pulse: return one dime |
| ret_n | output | 1 | One-cycle pulse: return one nickel |

## Verification
Some properties of the output train are checked by assertions on every cycle:
- at most one output is high in any cycle;
- a return pulse only ever follows a vend or another return pulse;
- a vend is always preceded by a coin or by the end of a payout;
- the outputs are quiet just after reset.

Other behaviours need the bench's directed scenarios, which count cycles exactly:
- the exact cycle in which a vend appears;
- the largest-first order of change coins;
- the fresh credit that builds up during a payout and its follow-on vend.

A random coin run closes with a quarter. It then checks that value is conserved across all purchases, which no single-cycle property can capture.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // Which coin the change logic returns this cycle.
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_Q    = 2'd1,
    PICK_D    = 2'd2,
    PICK_N    = 2'd3
  } pick_e;
endpackage

// File: rtl/vend_coin_value.sv
// Maps the one-hot coin pulses to a credit increment in 5-cent units.
module vend_coin_value #(
  parameter int CW  = 8,
  parameter int Q_U = 5,
  parameter int D_U = 2,
  parameter int N_U = 1
) (
  input  logic          coin_q,
  input  logic          coin_d,
  input  logic          coin_n,
  output logic [CW-1:0] add_u
);
  always_comb begin
    if (coin_q)      add_u = CW'(Q_U);
    else if (coin_d) add_u = CW'(D_U);
    else if (coin_n) add_u = CW'(N_U);
    else             add_u = '0;
  end
endmodule

// File: rtl/vend_change_pick.sv
// Greedy choice of the next coin to return from the owed amount.
module vend_change_pick
  import vend_pkg::*;
#(
  parameter int CW  = 8,
  parameter int Q_U = 5,
  parameter int D_U = 2,
  parameter int N_U = 1
) (
  input  logic [CW-1:0] owed,
  output pick_e         pick,
  output logic [CW-1:0] rem
);
  localparam logic [CW-1:0] QV = CW'(Q_U);
  localparam logic [CW-1:0] DV = CW'(D_U);
  localparam logic [CW-1:0] NV = CW'(N_U);

  always_comb begin
    if (owed >= QV) begin
      pick = PICK_Q;
      rem  = owed - QV;
    end else if (owed >= DV) begin
      pick = PICK_D;
      rem  = owed - DV;
    end else if (owed >= NV && owed != '0) begin
      pick = PICK_N;
      rem  = owed - NV;
    end else begin
      pick = PICK_NONE;
      rem  = owed;
    end
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int CREDIT_W = 8,
  parameter int PRICE_U  = 5,
  parameter int Q_U      = 5,
  parameter int D_U      = 2,
  parameter int N_U      = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic coin_q,
  input  logic coin_d,
  input  logic coin_n,
  output logic vend,
  output logic ret_q,
  output logic ret_d,
  output logic ret_n
);
  localparam logic [CREDIT_W-1:0] PRICE = CREDIT_W'(PRICE_U);

  logic [CREDIT_W-1:0] acc_q;    // credit toward the next purchase
  logic [CREDIT_W-1:0] owed_q;   // change still to be paid
  logic [CREDIT_W-1:0] add_u;
  logic [CREDIT_W-1:0] sum;
  logic [CREDIT_W-1:0] rem;
  pick_e               pick;

  vend_coin_value #(.CW(CREDIT_W), .Q_U(Q_U), .D_U(D_U), .N_U(N_U)) u_val (
    .coin_q (coin_q),
    .coin_d (coin_d),
    .coin_n (coin_n),
    .add_u  (add_u)
  );

  vend_change_pick #(.CW(CREDIT_W), .Q_U(Q_U), .D_U(D_U), .N_U(N_U)) u_pick (
    .owed (owed_q),
    .pick (pick),
    .rem  (rem)
  );

  assign sum = acc_q + add_u;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      owed_q <= '0;
      vend   <= 1'b0;
      ret_q  <= 1'b0;
      ret_d  <= 1'b0;
      ret_n  <= 1'b0;
    end else begin
      vend  <= 1'b0;
      ret_q <= 1'b0;
      ret_d <= 1'b0;
      ret_n <= 1'b0;
      if (pick != PICK_NONE) begin
        // paying change; incoming coins build fresh credit
        ret_q  <= (pick == PICK_Q);
        ret_d  <= (pick == PICK_D);
        ret_n  <= (pick == PICK_N);
        owed_q <= rem;
        acc_q  <= sum;
      end else if (sum >= PRICE) begin
        vend   <= 1'b1;
        owed_q <= sum - PRICE;
        acc_q  <= '0;
      end else begin
        acc_q  <= sum;
      end
    end
  end
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic coin_q,
  input logic coin_d,
  input logic coin_n,
  input logic vend,
  input logic ret_q,
  input logic ret_d,
  input logic ret_n
);
  logic any_ret, any_out, any_coin;
  assign any_ret  = ret_q | ret_d | ret_n;
  assign any_out  = vend | any_ret;
  assign any_coin = coin_q | coin_d | coin_n;

  // R6
  p_one_output_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vend, ret_q, ret_d, ret_n}));

  // R4
  p_change_follows_r4: assert property (@(posedge clk) disable iff (rst)
    any_ret |-> $past(any_out));

  // R3
  p_vend_cause_r3: assert property (@(posedge clk) disable iff (rst)
    vend |-> $past(any_coin | any_out));

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !any_out);
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .coin_q (coin_q),
  .coin_d (coin_d),
  .coin_n (coin_n),
  .vend   (vend),
  .ret_q  (ret_q),
  .ret_d  (ret_d),
  .ret_n  (ret_n)
);

// File: tb/vend_ctrl_bench.sv
module vend_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_q = 1'b0, coin_d = 1'b0, coin_n = 1'b0;
  logic vend, ret_q, ret_d, ret_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // coin codes for the tasks
  localparam int NO = 0, CN = 1, CD = 2, CQ = 3;
  // expected output vectors {vend, ret_q, ret_d, ret_n}
  localparam logic [3:0] O0 = 4'b0000, OV = 4'b1000, RQ = 4'b0100,
                         RD = 4'b0010, RN = 4'b0001;

  bit mon_en = 1'b0;
  int mon_vends = 0;
  int mon_ret   = 0;
  int inserted  = 0;

  always #2 clk = ~clk;  // 250 MHz

  vend_ctrl u_vend_ctrl (
    .clk(clk), .rst(rst), .coin_q(coin_q), .coin_d(coin_d), .coin_n(coin_n),
    .vend(vend), .ret_q(ret_q), .ret_d(ret_d), .ret_n(ret_n)
  );

  always @(negedge clk) begin
    if (mon_en) begin
      mon_vends += int'(vend);
      mon_ret   += 25 * int'(ret_q) + 10 * int'(ret_d) + 5 * int'(ret_n);
    end
  end

  task automatic check(input string req, input logic [3:0] exp);
    n_cmp++;
    if ({vend, ret_q, ret_d, ret_n} !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b at %0t", req,
               {vend, ret_q, ret_d, ret_n}, exp, $time);
    end
  endtask

  // Check outputs now, drive a coin for one cycle, move to the next negedge.
  task automatic step(input int c, input logic [3:0] exp, input string req);
    check(req, exp);
    coin_q = (c == CQ);
    coin_d = (c == CD);
    coin_n = (c == CN);
    inserted += (c == CQ) ? 25 : (c == CD) ? 10 : (c == CN) ? 5 : 0;
    @(negedge clk);
    coin_q = 1'b0; coin_d = 1'b0; coin_n = 1'b0;
  endtask

  task automatic drive(input int c);
    coin_q = (c == CQ);
    coin_d = (c == CD);
    coin_n = (c == CN);
    inserted += (c == CQ) ? 25 : (c == CD) ? 10 : (c == CN) ? 5 : 0;
    @(negedge clk);
    coin_q = 1'b0; coin_d = 1'b0; coin_n = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 during reset", O0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 first cycle after reset", O0);
    // leave credit behind, then reset it away
    step(CD, O0, "R1 pre");
    step(CD, O0, "R1 pre");
    do_reset();
    step(CQ, O0, "R1");
    step(NO, OV, "R1 quarter after reset vends");
    step(NO, O0, "R1 no change after cleared credit");
  endtask

  task automatic t_exact_quarter();
    step(CQ, O0, "R3");
    step(NO, OV, "R3 vend next cycle");
    step(NO, O0, "R3 vend one cycle");
    step(NO, O0, "R4 no change for exact price");
  endtask

  task automatic t_nickels();
    for (int i = 0; i < 4; i++) step(CN, O0, "R2 below price quiet");
    step(NO, O0, "R2 four nickels no vend");
    step(CN, O0, "R2");
    step(NO, OV, "R2 fifth nickel vends");
    step(NO, O0, "R4 no change at 25c");
  endtask

  task automatic t_three_dimes();
    step(CD, O0, "R2");
    step(CD, O0, "R2");
    step(CD, O0, "R2 twenty cents quiet");
    step(NO, OV, "R3 vend at 30c");
    step(NO, RN, "R5 5c change as nickel");
    step(NO, O0, "R4 change ends");
  endtask

  task automatic t_forty_five();
    step(CD, O0, "R5");
    step(CD, O0, "R5");
    step(CQ, O0, "R5");
    step(NO, OV, "R3 vend at 45c");
    step(NO, RD, "R5 first dime of 20c");
    step(NO, RD, "R5 second dime of 20c");
    step(NO, O0, "R4 change total 20c");
  endtask

  task automatic t_forty();
    step(CN, O0, "R5");
    step(CD, O0, "R5");
    step(CQ, O0, "R5");
    step(NO, OV, "R3 vend at 40c");
    step(NO, RD, "R5 dime first for 15c");
    step(NO, RN, "R5 nickel second for 15c");
    step(NO, O0, "R4 change total 15c");
  endtask

  task automatic t_fresh_vend();
    step(CD, O0, "R7");
    step(CD, O0, "R7");
    step(CQ, O0, "R7");
    step(NO, OV, "R7 first vend");
    step(CQ, RD, "R7 quarter during payout");
    step(NO, RD, "R7 payout continues");
    step(NO, OV, "R7 vend right after payout");
    step(NO, O0, "R7 no extra change");
  endtask

  task automatic t_fresh_kept();
    step(CD, O0, "R7");
    step(CD, O0, "R7");
    step(CQ, O0, "R7");
    step(CD, OV, "R7 dime during vend cycle");
    step(NO, RD, "R7");
    step(NO, RD, "R7");
    step(NO, O0, "R7 fresh 10c held, no vend");
    step(CD, O0, "R7 held credit");
    step(CN, O0, "R7 20c held");
    step(NO, OV, "R7 held credit completes purchase");
    step(NO, O0, "R7 exact, no change");
  endtask

  task automatic t_quarter_change();
    step(CD, O0, "R5");
    step(CD, O0, "R5");
    step(CQ, O0, "R5");
    step(CQ, OV, "R5");
    step(CQ, RD, "R5");
    step(NO, RD, "R5");
    step(NO, OV, "R5 vend from 50c fresh credit");
    step(NO, RQ, "R5 quarter returned for 25c");
    step(NO, O0, "R5 payout done");
  endtask

  task automatic t_random();
    inserted  = 0;
    mon_vends = 0;
    mon_ret   = 0;
    mon_en    = 1'b1;
    for (int i = 0; i < 80; i++) begin
      drive(int'($urandom_range(1, 3)));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    drive(CQ);
    repeat (40) @(negedge clk);
    mon_en = 1'b0;
    n_cmp++;
    if (inserted - mon_ret != 25 * mon_vends) begin
      n_bad++;
      $display("FAIL R8: inserted-returned %0d expected %0d", inserted - mon_ret,
               25 * mon_vends);
    end
    n_cmp++;
    if (mon_vends < 1) begin
      n_bad++;
      $display("FAIL R8: vends %0d expected at least %0d", mon_vends, 1);
    end
    step(CN, O0, "R8 idle after run");
    step(NO, O0, "R8 credit drained");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_exact_quarter();
    t_nickels();
    t_three_dimes();
    t_forty_five();
    t_forty();
    t_fresh_vend();
    t_fresh_kept();
    t_quarter_change();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule